// File: doc/BRIEF.md
# External Interrupt Request Controller

The block watches six asynchronous interrupt pins and turns qualifying transitions on them into pending requests. Each pin has its own byte-wide control register. The register holds a 3-bit priority level, a polarity select and a sticky request flag. A shared edge-select register can put any pin into both-edge mode, and that mode overrides the polarity select. Each pin passes through a two-flop synchronizer and an edge detector before it sets the flag.

A priority resolver looks at all pending requests that have a nonzero level. It presents one of them to the processor side as a valid, channel and level triple. An acknowledge input clears the request flag of the channel being presented. Software can also clear a flag through a simple register read/write port, but it can never set one. When the hardware sets a flag in the same cycle that a clear arrives, the set wins, so no edge is lost.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every channel register (addresses 0 to 5) and the edge-select register (address 6) read 0, and `irq_valid` is 0.
- R2: A channel register reads as {3'b000, polarity, request, level[2:0]}. Bits [7:5] always read 0 whatever was written. The edge-select register reads its six mode bits in [5:0] and 0 in [7:6]. An address with no register reads 0.
- R3: Polarity bit 4 set to 0 selects falling edges and set to 1 selects rising edges. The request flag (bit 3) reads 1 from the third rising clock edge after the pin changes.
- R4: When bit i of the edge-select register is 1, channel i sets its flag on both rising and falling pin edges, whatever its polarity bit holds.
- R5: A write to a channel register loads the level from bits [2:0] and the polarity from bit 4. Bit 3 written as 0 clears the flag; bit 3 written as 1 leaves the flag unchanged.
- R6: When a qualifying edge and a clear (a register write or an acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R7: `irq_valid` is 1 when some channel is pending with a nonzero level. `irq_chan` and `irq_level` then name the pending channel with the highest level. A tie goes to the lowest channel number.
- R8: A channel with level 0 still latches its flag but is never presented. When nothing can be presented, `irq_valid`, `irq_chan` and `irq_level` are all 0.
- R9: A pulse on `irq_ack` while `irq_valid` is 1 clears only the flag of the channel shown on `irq_chan`.
- R10: An edge in the direction the polarity bit does not select leaves the flag unchanged when both-edge mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| irq_pin | input | 6 | Asynchronous interrupt pins, one per channel |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 to 5 channel registers, 6 edge-select register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq_ack | input | 1 | Acknowledge of the presented request |
| irq_valid | output | 1 | A request is being presented |
| irq_chan | output | 3 | Channel number of the presented request |
| irq_level | output | 3 | Level of the presented request |

## Verification
Two functions can act on one request flag in the same clock: a hardware set from a detected edge, and a clear from either a register write or an acknowledge. The bench changes a pin and then launches the clear exactly two clocks later. At that point the edge detector's hit is active, so both operations land on the same rising edge. The flag is then read back and the presented triple is inspected, and both must show the request still pending. Without the set taking priority, the flag would read 0.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  localparam int LVL_W    = 3;
  localparam int CTRL_W   = 8;
  localparam int BIT_REQ  = 3;
  localparam int BIT_POL  = 4;

  // Edge qualification: both-edge mode overrides the polarity select
  function automatic logic edge_qualifies(input logic cur, input logic prev,
                                          input logic pol, input logic both);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (both) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Channel register image as seen on a read
  function automatic logic [CTRL_W-1:0] pack_ctrl(input logic [LVL_W-1:0] lvl,
                                                  input logic flag,
                                                  input logic pol);
    return {3'b000, pol, flag, lvl};
  endfunction

  // Strictly greater wins, so a scan from channel 0 upward keeps the lowest on a tie
  function automatic logic lvl_beats(input logic [LVL_W-1:0] cand,
                                     input logic [LVL_W-1:0] best);
    return cand > best;
  endfunction

endpackage

// File: rtl/irq_edge_chan.sv
module irq_edge_chan
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  input  logic both,
  input  logic clr,
  output logic hit,
  output logic flag
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= cur;
    end
  end

  assign hit = edge_qualifies(cur, prev_q, pol, both);

  // Set has priority over clear
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  p_flag_set_on_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  p_no_rise_without_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !$rose(flag));
  p_clear_drops_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int CH_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       req,
  input  logic [NUM_CH*LVL_W-1:0] lvl_flat,
  output logic                    valid,
  output logic [CH_W-1:0]         chan,
  output logic [LVL_W-1:0]        level
);

  logic [LVL_W-1:0] best_lvl;
  logic [CH_W-1:0]  best_ch;

  always_comb begin
    best_lvl = '0;
    best_ch  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (req[i] && lvl_beats(lvl_flat[i*LVL_W +: LVL_W], best_lvl)) begin
        best_lvl = lvl_flat[i*LVL_W +: LVL_W];
        best_ch  = CH_W'(i);
      end
    end
  end

  assign valid = (best_lvl != '0);
  assign chan  = best_ch;
  assign level = best_lvl;

  p_valid_has_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (level != '0));
  p_granted_is_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> req[chan]);
  p_idle_outputs_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (chan == '0 && level == '0));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  parameter int CH_W        = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_pin,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic              irq_ack,
  output logic              irq_valid,
  output logic [CH_W-1:0]   irq_chan,
  output logic [LVL_W-1:0]  irq_level
);

  localparam logic [ADDR_W-1:0] EDGE_ADDR = ADDR_W'(NUM_CH);

  logic [NUM_CH*LVL_W-1:0] lvl_flat;
  logic [NUM_CH-1:0]       pol_q;
  logic [NUM_CH-1:0]       both_q;
  logic [NUM_CH-1:0]       flag;
  logic [NUM_CH-1:0]       hit;
  logic [NUM_CH-1:0]       clr;
  logic                    edge_wr;

  assign edge_wr = bus_we && (bus_addr == EDGE_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)       both_q <= '0;
    else if (edge_wr) both_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic ch_wr;
    logic ack_hit;

    assign ch_wr   = bus_we && (bus_addr == ADDR_W'(g));
    assign ack_hit = irq_ack && irq_valid && (irq_chan == CH_W'(g));
    assign clr[g]  = (ch_wr && !bus_wdata[BIT_REQ]) || ack_hit;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_flat[g*LVL_W +: LVL_W] <= '0;
        pol_q[g]                   <= 1'b0;
      end else if (ch_wr) begin
        lvl_flat[g*LVL_W +: LVL_W] <= bus_wdata[LVL_W-1:0];
        pol_q[g]                   <= bus_wdata[BIT_POL];
      end
    end

    irq_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (irq_pin[g]),
      .pol  (pol_q[g]),
      .both (both_q[g]),
      .clr  (clr[g]),
      .hit  (hit[g]),
      .flag (flag[g])
    );
  end

  irq_prio_resolver #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_resolver (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (flag),
    .lvl_flat(lvl_flat),
    .valid   (irq_valid),
    .chan    (irq_chan),
    .level   (irq_level)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(i))
        bus_rdata = pack_ctrl(lvl_flat[i*LVL_W +: LVL_W], flag[i], pol_q[i]);
    end
    if (bus_addr == EDGE_ADDR) bus_rdata = CTRL_W'(both_q);
  end

  p_reserved_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr < EDGE_ADDR) |-> (bus_rdata[7:5] == 3'b000));
  p_reserved_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_wdata[7:5] != 3'b000) |=> (bus_rdata[7:6] == 2'b00));
  p_ack_only_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !bus_we) |-> $onehot0(clr));

endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] irq_pin;
  logic       bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_ack;
  logic       irq_valid;
  logic [2:0] irq_chan;
  logic [2:0] irq_level;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  ext_irq_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_pin  (irq_pin),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_ack  (irq_ack),
    .irq_valid(irq_valid),
    .irq_chan (irq_chan),
    .irq_level(irq_level)
  );

  // Inputs change 2 ns after a rising edge; the monitor samples on the falling edge
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  task automatic settle();
    repeat (4) tick();
  endtask

  // Register image {000, pol, flag, level}
  task automatic chk_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    tick();
  endtask

  // Presented triple packed as {0, valid, chan, level}
  task automatic chk_irq(input logic v, input logic [2:0] c, input logic [2:0] l,
                         input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {1'b0, v, c, l}; it.tag = tag;
    sb_q.push_back(it);
    tick();
  endtask

  initial begin : monitor
    item_t      it;
    logic [7:0] act;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        it  = sb_q.pop_front();
        act = it.is_irq ? {1'b0, irq_valid, irq_chan, irq_level} : bus_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; irq_pin = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; irq_ack = 1'b0;
    repeat (5) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 7; a++) chk_reg(3'(a), 8'h00, "R1 reset register");
    chk_irq(1'b0, 3'd0, 3'd0, "R1 no request after reset");

    // R2 / R5: reserved bits read 0, writing 1 to the flag does not set it
    wr(3'd0, 8'hFF);
    chk_reg(3'd0, 8'h17, "R2 R5 write all ones");
    wr(3'd0, 8'h05);
    chk_reg(3'd0, 8'h05, "R5 level and polarity load");

    // R10 rising ignored with falling polarity, R3 falling sets
    irq_pin[0] = 1'b1; settle();
    chk_reg(3'd0, 8'h05, "R10 wrong-direction edge");
    irq_pin[0] = 1'b0;
    repeat (3) tick();
    chk_reg(3'd0, 8'h0D, "R3 falling edge latency");
    chk_irq(1'b1, 3'd0, 3'd5, "R7 single pending");

    // R3 rising polarity, R7 tie goes low
    wr(3'd1, 8'h15);
    irq_pin[1] = 1'b1; settle();
    chk_reg(3'd1, 8'h1D, "R3 rising edge");
    chk_irq(1'b1, 3'd0, 3'd5, "R7 tie lowest channel");
    wr(3'd2, 8'h16);
    irq_pin[2] = 1'b1; settle();
    chk_irq(1'b1, 3'd2, 3'd6, "R7 highest level");

    // R9 acknowledge clears the granted channel only
    ack();
    chk_reg(3'd2, 8'h16, "R9 granted flag cleared");
    chk_reg(3'd0, 8'h0D, "R9 other flag kept");
    chk_irq(1'b1, 3'd0, 3'd5, "R9 next grant");

    // R8 level 0 latches but is not presented
    wr(3'd3, 8'h10);
    irq_pin[3] = 1'b1; settle();
    chk_reg(3'd3, 8'h18, "R8 level-0 flag latched");
    chk_irq(1'b1, 3'd0, 3'd5, "R8 level-0 not presented");
    wr(3'd0, 8'h05);
    chk_reg(3'd0, 8'h05, "R5 software clear");
    chk_irq(1'b1, 3'd1, 3'd5, "R7 after clear");
    wr(3'd1, 8'h15);
    chk_irq(1'b0, 3'd0, 3'd0, "R8 idle with only level-0 pending");

    // R4 both-edge mode
    wr(3'd6, 8'hFF);
    chk_reg(3'd6, 8'h3F, "R2 edge-select upper bits");
    wr(3'd6, 8'h10);
    chk_reg(3'd6, 8'h10, "R4 edge-select readback");
    wr(3'd4, 8'h03);
    irq_pin[4] = 1'b1; settle();
    chk_reg(3'd4, 8'h0B, "R4 rising in both-edge mode");
    wr(3'd4, 8'h03);
    chk_reg(3'd4, 8'h03, "R5 clear before falling");
    irq_pin[4] = 1'b0; settle();
    chk_reg(3'd4, 8'h0B, "R4 falling in both-edge mode");
    chk_irq(1'b1, 3'd4, 3'd3, "R7 both-edge channel presented");

    // R6 hardware set against software write clear in the same cycle
    wr(3'd5, 8'h01);
    irq_pin[5] = 1'b1; settle();
    irq_pin[5] = 1'b0; settle();
    chk_reg(3'd5, 8'h09, "R3 channel 5 pending");
    irq_pin[5] = 1'b1; settle();
    irq_pin[5] = 1'b0;
    tick(); tick();
    wr(3'd5, 8'h01);
    chk_reg(3'd5, 8'h09, "R6 set wins over write clear");

    // R6 hardware set against acknowledge in the same cycle
    irq_pin[4] = 1'b1;
    tick(); tick();
    ack();
    chk_reg(3'd4, 8'h0B, "R6 set wins over acknowledge");
    chk_irq(1'b1, 3'd4, 3'd3, "R6 still presented");

    ack();
    chk_irq(1'b1, 3'd5, 3'd1, "R9 ack moves to next");
    ack();
    chk_irq(1'b0, 3'd0, 3'd0, "R8 level-0 left pending only");
    chk_reg(3'd3, 8'h18, "R8 level-0 flag still set");

    repeat (3) tick();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule